// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block turns a table of scatter-gather descriptors held in memory into a stream of transfer segments for a data mover. Software lays out the table as a list of 8-byte entries. Each entry names a buffer address and a byte count, and one entry can carry an end marker. The walker gets a pulse together with the table's base address and a byte budget for the whole transfer. It then fetches entries one at a time over a simple request/response read port. It hands out (address, length) segments under a valid/ready handshake until the budget is spent, the table ends, or a fail-safe limit of one 4 KiB page of descriptors is reached.

A second launch input re-walks the table from the base address that the last fresh launch latched. A cancel input stops the walk cleanly between handshakes. When a walk finishes normally, a one-cycle completion pulse reports why it stopped: end of table, page limit, or budget spent. A separate flag reports that the table ran out before the budget did.

Top module: `sg_table_walker`

## Requirements
- R1: A descriptor arrives on `memRspData` as one 64-bit little-endian beat. Bits [31:0] are the buffer address and bits [63:32] are the control word. The byte count is control bits [15:1] times two, so bit 0 is ignored. A count of zero means 65536 bytes. Control bit 31 (data bit 63) marks the last entry.
- R2: Descriptor reads go to the base address plus 8 times the number of entries fetched so far. A read is issued only when the remaining bytes of the current descriptor are zero. The first read request is raised at the second clock edge after the launch edge.
- R3: Each segment's length is the smaller of the remaining budget and the remaining descriptor bytes. It is never zero. The next segment from the same descriptor starts at the previous address plus the previous length.
- R4: When the descriptor that carries the last mark is used up, the walk ends with `done` and `tableEnd` both high. In that same cycle `underrun` is high exactly when budget remains.
- R5: When the budget reaches zero before the table ends, the walk ends with `done` high, all three cause flags low, and no further descriptor read.
- R6: When a new descriptor is needed and the read pointer minus the base is at least 4096, the walk ends with `done`, `pageStop` and `underrun` high. At most 512 descriptors are read per walk.
- R7: A `restart` pulse while idle launches a walk from the base address latched by the most recent `start`. It ignores the present value of `baseAddr` and takes a new budget from `byteBudget`.
- R8: `start` and `restart` pulses are ignored while a walk is in progress.
- R9: A `cancel` pulse during a walk lets any handshake already offered complete. After that, no further segment or read is offered, no `done` is produced, and the walker returns to idle, ready for a new launch.
- R10: `segValid` and `memReqValid` each stay high with a stable payload until accepted. The two are never high together.
- R11: During and right after reset, every valid, ready and status output is low.
- R12: `done` is a single-cycle pulse, and the cause flags are high only together with it. A launch with a zero budget raises `done` at the second edge after the launch edge, with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a walk from `baseAddr` |
| restart | input | 1 | Launch a walk from the latched base |
| cancel | input | 1 | Abort the walk at the next handshake boundary |
| baseAddr | input | ADDR_W | Table base address for `start` |
| byteBudget | input | BUDGET_W | Total bytes to hand out in this walk |
| memReqValid | output | 1 | Descriptor read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | ADDR_W | Address of the 8-byte entry to read |
| memRspValid | input | 1 | Read response valid |
| memRspReady | output | 1 | Walker takes the response |
| memRspData | input | 64 | Descriptor beat |
| segValid | output | 1 | Segment valid |
| segReady | input | 1 | Segment accepted by the data mover |
| segAddr | output | ADDR_W | Segment start address |
| segLen | output | 17 | Segment length in bytes (1..65536) |
| done | output | 1 | Walk completed (one cycle) |
| tableEnd | output | 1 | Stopped on the last-marked entry |
| pageStop | output | 1 | Stopped by the one-page descriptor limit |
| underrun | output | 1 | Table ended with budget left |

## Verification
After a launch, the walker spends one edge deciding, so the first read request or the zero-budget `done` shows at the second edge. The bench checks these at the falling edges after the first and the second launch edge. Once a response is taken, or a segment is accepted, there is another one-edge decision step before the next segment or `done`. The bench therefore never counts fixed delays for those. It records every accepted handshake at the falling edge before the edge that takes it, and compares the complete segment list, the read count and the stop flags once `done` is seen. For cancel, the bench waits three edges to let an offered handshake finish, then confirms over fifty more cycles that nothing moves.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFresh;    // latch base and budget, point at base
    logic loadRestart;  // point at latched base, take new budget
    logic advPtr;       // table pointer += entry size
    logic takeDesc;     // capture fetched descriptor
    logic takeSeg;      // consume the offered segment
  } walkCmd_t;

  // conditions reported back to control
  typedef struct packed {
    logic descEmpty;
    logic lastSeen;
    logic budgetZero;
    logic pageFull;
  } walkStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_REQ, ST_RSP, ST_SEG, ST_DONE
  } walkState_t;

endpackage

// File: rtl/sg_walk_dp.sv
module sg_walk_dp
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUDGET_W   = 24,
  parameter int PAGE_BYTES = 4096,
  parameter int ENTRY_B    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkCmd_t            cmd,
  input  logic [ADDR_W-1:0]   baseIn,
  input  logic [BUDGET_W-1:0] budgetIn,
  input  logic [ADDR_W-1:0]   rspBufAddr,
  input  logic [15:1]         rspCount,
  input  logic                rspLast,
  output walkStat_t           stat,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [ADDR_W-1:0]   segAddr,
  output logic [16:0]         segLen
);

  localparam int LEN_W = 17;
  localparam int CMP_W = (BUDGET_W > LEN_W) ? BUDGET_W : LEN_W;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(65536);

  logic [ADDR_W-1:0]   baseQ, ptrQ, descAddrQ;
  logic [LEN_W-1:0]    descRemQ;
  logic                lastQ;
  logic [BUDGET_W-1:0] budgetQ;

  logic [LEN_W-1:0] decodedLen;
  logic [CMP_W-1:0] budgetW, remW, pickW;

  // an even count of zero stands for a full 64 KiB buffer
  always_comb begin
    decodedLen = {1'b0, rspCount, 1'b0};
    if (rspCount == '0) decodedLen = FULL_LEN;
  end

  always_comb begin
    budgetW = CMP_W'(budgetQ);
    remW    = CMP_W'(descRemQ);
    pickW   = (budgetW < remW) ? budgetW : remW;
  end

  assign segLen  = pickW[LEN_W-1:0];
  assign segAddr = descAddrQ;
  assign reqAddr = ptrQ;

  assign stat.descEmpty  = (descRemQ == '0);
  assign stat.lastSeen   = lastQ;
  assign stat.budgetZero = (budgetQ == '0);
  assign stat.pageFull   = ((ptrQ - baseQ) >= ADDR_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      ptrQ      <= '0;
      descAddrQ <= '0;
      descRemQ  <= '0;
      lastQ     <= 1'b0;
      budgetQ   <= '0;
    end else begin
      if (cmd.loadFresh || cmd.loadRestart) begin
        descAddrQ <= '0;
        descRemQ  <= '0;
        lastQ     <= 1'b0;
        budgetQ   <= budgetIn;
      end
      if (cmd.loadFresh) begin
        baseQ <= baseIn;
        ptrQ  <= baseIn;
      end
      if (cmd.loadRestart) ptrQ <= baseQ;
      if (cmd.advPtr) ptrQ <= ptrQ + ADDR_W'(ENTRY_B);
      if (cmd.takeDesc) begin
        descAddrQ <= rspBufAddr;
        descRemQ  <= decodedLen;
        lastQ     <= rspLast;
      end
      if (cmd.takeSeg) begin
        descAddrQ <= descAddrQ + ADDR_W'(segLen);
        descRemQ  <= descRemQ - segLen;
        budgetQ   <= budgetQ - BUDGET_W'(segLen);
      end
    end
  end

endmodule

// File: rtl/sg_walk_ctrl.sv
module sg_walk_ctrl
  import sg_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      restart,
  input  logic      cancel,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      segReady,
  input  walkStat_t stat,
  output walkCmd_t  cmd,
  output logic      memReqValid,
  output logic      memRspReady,
  output logic      segValid,
  output logic      done,
  output logic      tableEnd,
  output logic      pageStop,
  output logic      underrun
);

  walkState_t state, stateN;
  logic cancelPend;
  logic endN, pageN, underN;

  always_comb begin
    stateN      = state;
    cmd         = '0;
    memReqValid = 1'b0;
    memRspReady = 1'b0;
    segValid    = 1'b0;
    endN        = 1'b0;
    pageN       = 1'b0;
    underN      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.loadFresh = 1'b1;
          stateN = ST_DECIDE;
        end else if (restart) begin
          cmd.loadRestart = 1'b1;
          stateN = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (cancelPend || cancel) begin
          stateN = ST_IDLE;
        end else if (stat.descEmpty && stat.lastSeen) begin
          stateN = ST_DONE;
          endN   = 1'b1;
          underN = !stat.budgetZero;
        end else if (stat.budgetZero) begin
          stateN = ST_DONE;
        end else if (stat.descEmpty && stat.pageFull) begin
          stateN = ST_DONE;
          pageN  = 1'b1;
          underN = 1'b1;
        end else if (stat.descEmpty) begin
          stateN = ST_REQ;
        end else begin
          stateN = ST_SEG;
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          cmd.advPtr = 1'b1;
          stateN = ST_RSP;
        end
      end
      ST_RSP: begin
        memRspReady = 1'b1;
        if (memRspValid) begin
          cmd.takeDesc = 1'b1;
          stateN = ST_DECIDE;
        end
      end
      ST_SEG: begin
        segValid = 1'b1;
        if (segReady) begin
          cmd.takeSeg = 1'b1;
          stateN = ST_DECIDE;
        end
      end
      ST_DONE: stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cancelPend <= 1'b0;
      tableEnd   <= 1'b0;
      pageStop   <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      state      <= stateN;
      cancelPend <= (state != ST_IDLE) && (stateN != ST_IDLE) && (cancelPend || cancel);
      tableEnd   <= endN;
      pageStop   <= pageN;
      underrun   <= underN;
    end
  end

endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUDGET_W   = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                restart,
  input  logic                cancel,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [BUDGET_W-1:0] byteBudget,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  output logic                memRspReady,
  input  logic [63:0]         memRspData,
  output logic                segValid,
  input  logic                segReady,
  output logic [ADDR_W-1:0]   segAddr,
  output logic [16:0]         segLen,
  output logic                done,
  output logic                tableEnd,
  output logic                pageStop,
  output logic                underrun
);

  walkCmd_t  cmd;
  walkStat_t stat;

  // reserved descriptor bits carry no meaning
  logic unusedRsvd;
  assign unusedRsvd = &{1'b0, memRspData[62:48], memRspData[32]};

  sg_walk_ctrl u_ctrl (
    .clk, .rstN, .start, .restart, .cancel,
    .memReqReady, .memRspValid, .segReady, .stat, .cmd,
    .memReqValid, .memRspReady, .segValid,
    .done, .tableEnd, .pageStop, .underrun
  );

  sg_walk_dp #(
    .ADDR_W(ADDR_W), .BUDGET_W(BUDGET_W), .PAGE_BYTES(PAGE_BYTES), .ENTRY_B(8)
  ) u_dp (
    .clk, .rstN, .cmd,
    .baseIn(baseAddr), .budgetIn(byteBudget),
    .rspBufAddr(memRspData[ADDR_W-1:0]),
    .rspCount(memRspData[47:33]),
    .rspLast(memRspData[63]),
    .stat, .reqAddr(memReqAddr), .segAddr, .segLen
  );

endmodule

// File: rtl/sg_walk_checker.sv
module sg_walk_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              segValid,
  input logic              segReady,
  input logic [ADDR_W-1:0] segAddr,
  input logic [16:0]       segLen,
  input logic              done,
  input logic              tableEnd,
  input logic              pageStop,
  input logic              underrun
);

  p_seg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid && $stable(segAddr) && $stable(segLen));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  p_one_offer_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(segValid && memReqValid));

  p_seg_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> (segLen != 17'd0) && (segLen <= 17'h10000));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_flags_need_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    (tableEnd || pageStop || underrun) |-> done);

  p_one_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(tableEnd && pageStop));

  p_page_under_r6: assert property (@(posedge clk) disable iff (!rstN)
    pageStop |-> underrun);

endmodule

bind sg_table_walker sg_walk_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sg_table_walker.sv
module sim_sg_table_walker;

  localparam int AW = 32;
  localparam int BW = 24;
  localparam logic [31:0] MEMBASE = 32'h1000_0000;
  localparam int MEMWORDS = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, restart = 0, cancel = 0;
  logic [AW-1:0] baseAddr = '0;
  logic [BW-1:0] byteBudget = '0;
  logic memReqValid, memReqReady = 0, memRspValid = 0, memRspReady;
  logic [AW-1:0] memReqAddr;
  logic [63:0] memRspData = '0;
  logic segValid, segReady = 0;
  logic [AW-1:0] segAddr;
  logic [16:0] segLen;
  logic done, tableEnd, pageStop, underrun;

  always #10 clk = ~clk;  // 50 MHz

  sg_table_walker #(.ADDR_W(AW), .BUDGET_W(BW), .PAGE_BYTES(4096)) u0 (.*);

  logic [63:0] descMem [0:MEMWORDS-1];
  logic [31:0] gotAddr [0:2047];
  longint      gotLen  [0:2047];
  logic [31:0] expAddr [0:2047];
  longint      expLen  [0:2047];
  int gotCnt, expCnt, reqCount, expFetch, doneCount, cyc, stallMode;
  bit doneFlag, gotEnd, gotPage, gotUnder, expEnd, expPage, expUnder;
  bit rspPending;
  logic [31:0] pendAddr;
  int checks = 0, fails = 0;

  function automatic logic [63:0] mkDesc(input logic [31:0] a, input logic [15:0] cnt, input bit last);
    return {last, 15'd0, cnt, a};
  endfunction

  function automatic logic [63:0] memRead(input logic [31:0] a);
    logic [31:0] idx = (a - MEMBASE) >> 3;
    if (idx < MEMWORDS) return descMem[idx];
    return 64'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory responder, segment sink and completion monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      memRspValid = 1'b0;
      if (!rstN) begin
        rspPending = 0;
        memReqReady = 0;
        segReady = 0;
      end else begin
        if (rspPending) begin
          memRspValid = 1'b1;
          memRspData = memRead(pendAddr);
          rspPending = 0;
        end
        memReqReady = (stallMode == 0) ? 1'b1 : (cyc % 2 == 0);
        segReady    = (stallMode == 0) ? 1'b1 : (cyc % 3 != 0);
        if (memReqValid && memReqReady) begin
          rspPending = 1;
          pendAddr = memReqAddr;
          reqCount++;
        end
        if (segValid && segReady && gotCnt < 2048) begin
          gotAddr[gotCnt] = segAddr;
          gotLen[gotCnt] = segLen;
          gotCnt++;
        end
        if (done) begin
          doneCount++;
          doneFlag = 1;
          gotEnd = tableEnd;
          gotPage = pageStop;
          gotUnder = underrun;
        end
      end
    end
  end

  task automatic refModel(input logic [31:0] tbl, input longint budget);
    logic [31:0] ptr = tbl, da = 0;
    longint rem = 0, b = budget, l;
    bit last = 0;
    logic [63:0] w;
    expCnt = 0; expFetch = 0; expEnd = 0; expPage = 0; expUnder = 0;
    for (int g = 0; g < 5000; g++) begin
      if (rem == 0 && last) begin expEnd = 1; expUnder = (b != 0); break; end
      if (b == 0) break;
      if (rem == 0 && (ptr - tbl) >= 4096) begin expPage = 1; expUnder = 1; break; end
      if (rem == 0) begin
        w = memRead(ptr);
        ptr += 8;
        expFetch++;
        da = w[31:0];
        rem = {w[47:33], 1'b0};
        if (rem == 0) rem = 65536;
        last = w[63];
      end else begin
        l = (b < rem) ? b : rem;
        expAddr[expCnt] = da;
        expLen[expCnt] = l;
        expCnt++;
        da += l[31:0];
        rem -= l;
        b -= l;
      end
    end
  endtask

  task automatic launch(input bit useRestart, input logic [31:0] base, input longint budget);
    @(negedge clk);
    gotCnt = 0; reqCount = 0; doneFlag = 0;
    baseAddr = base;
    byteBudget = budget[BW-1:0];
    start = !useRestart;
    restart = useRestart;
    @(negedge clk);
    start = 0;
    restart = 0;
  endtask

  task automatic finishWalk(input string req, input string tag);
    bit segOk = 1;
    int bad = 0;
    for (int t = 0; t < 20000 && !doneFlag; t++) @(negedge clk);
    chk(doneFlag, req, {tag, " done seen"}, doneFlag, 1);
    chk(gotCnt == expCnt, req, {tag, " segment count"}, gotCnt, expCnt);
    for (int i = 0; i < expCnt && i < gotCnt; i++)
      if (segOk && (gotAddr[i] != expAddr[i] || gotLen[i] != expLen[i])) begin
        segOk = 0; bad = i;
      end
    chk(segOk, req, {tag, " segment list (addr/len at first mismatch)"},
        segOk ? 0 : gotLen[bad], segOk ? 0 : expLen[bad]);
    chk(reqCount == expFetch, req, {tag, " descriptor reads"}, reqCount, expFetch);
    chk({gotEnd, gotPage, gotUnder} == {expEnd, expPage, expUnder}, req, {tag, " stop flags end/page/under"},
        {gotEnd, gotPage, gotUnder}, {expEnd, expPage, expUnder});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
  end

  initial begin
    logic [15:0] lens [0:3];
    longint budgets [0:10];
    lens = '{16'h0002, 16'h0011, 16'h0100, 16'h0000};
    budgets = '{0, 1, 2, 15, 16, 17, 256, 257, 65536, 65538, 196608};
    for (int i = 0; i < MEMWORDS; i++) descMem[i] = 64'd0;
    stallMode = 0;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk({segValid, memReqValid, memRspReady, done, tableEnd, pageStop, underrun} == 7'd0,
        "R11", "outputs in reset", {segValid, memReqValid, memRspReady, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({segValid, memReqValid, memRspReady, done, tableEnd, pageStop, underrun} == 7'd0,
        "R11", "outputs after reset", {segValid, memReqValid, memRspReady, done}, 0);

    // R1: odd count 0x0101 means 0x100 bytes; R4 exact budget, no underrun
    descMem[0] = mkDesc(32'h2000_0000, 16'h0101, 1);
    refModel(MEMBASE, 256);
    launch(0, MEMBASE, 256);
    // R2: first request due at second edge after launch
    chk(memReqValid == 0, "R2", "request after first edge", memReqValid, 0);
    @(negedge clk);
    chk(memReqValid == 1 && memReqAddr == MEMBASE, "R2", "request at second edge", memReqAddr, MEMBASE);
    finishWalk("R1", "odd count R4");
    chk(expLen[0] == 256 && expEnd && !expUnder, "R4", "model sanity exact end", expLen[0], 256);

    // R1: zero count means 65536 bytes; R4 underrun with budget left
    descMem[0] = mkDesc(32'h2100_0000, 16'h0000, 1);
    refModel(MEMBASE, 70000);
    launch(0, MEMBASE, 70000);
    finishWalk("R1", "zero count R4 underrun");
    chk(gotLen[0] == 65536 && gotUnder, "R1", "64KiB length", gotLen[0], 65536);

    // R12: zero budget finishes at second edge with no read
    launch(0, MEMBASE, 0);
    chk(done == 0, "R12", "done after first edge", done, 0);
    @(negedge clk);
    chk(done == 1 && {tableEnd, pageStop, underrun} == 0 && reqCount == 0, "R12", "zero budget done", done, 1);

    // R6: page fail-safe, 513 unmarked entries of 2 bytes
    for (int i = 0; i < 513; i++) descMem[i] = mkDesc(32'h3000_0000 + i * 16, 16'h0002, 0);
    stallMode = 1;
    refModel(MEMBASE, 24'hFF_FFFF);
    launch(0, MEMBASE, 24'hFF_FFFF);
    finishWalk("R6", "page limit");
    chk(reqCount == 512, "R6", "reads capped at 512", reqCount, 512);

    // R9: cancel mid-walk
    stallMode = 0;
    launch(0, MEMBASE, 24'hFF_FFFF);
    for (int t = 0; t < 5000 && gotCnt < 3; t++) @(negedge clk);
    begin
      int n0, d0;
      d0 = doneCount;
      cancel = 1;
      @(negedge clk);
      cancel = 0;
      repeat (3) @(negedge clk);
      n0 = gotCnt;
      repeat (50) @(negedge clk);
      chk(gotCnt == n0, "R9", "no segment after cancel", gotCnt, n0);
      chk(doneCount == d0, "R9", "no done after cancel", doneCount, d0);
      chk(!segValid && !memReqValid, "R9", "idle after cancel", {segValid, memReqValid}, 0);
    end

    // R7: restart re-walks the latched base, ignoring baseAddr
    descMem[600] = mkDesc(32'h4000_0000, 16'h0040, 0);
    descMem[601] = mkDesc(32'h4100_0000, 16'h0020, 1);
    descMem[700] = mkDesc(32'h5000_0000, 16'h0008, 1);
    refModel(MEMBASE + 600 * 8, 90);
    launch(0, MEMBASE + 600 * 8, 90);
    finishWalk("R7", "fresh walk");
    launch(1, MEMBASE + 700 * 8, 90);
    finishWalk("R7", "restart walk");

    // R8: launches during a walk are ignored
    stallMode = 1;
    launch(0, MEMBASE + 600 * 8, 90);
    repeat (3) @(negedge clk);
    baseAddr = MEMBASE + 700 * 8;
    byteBudget = 5;
    start = 1;
    @(negedge clk);
    start = 0;
    restart = 1;
    @(negedge clk);
    restart = 0;
    finishWalk("R8", "busy launch ignored");

    // R3 / R4 / R5: sweep two-entry tables against many budgets
    for (int m = 0; m < 2; m++) begin
      stallMode = m;
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          descMem[800] = mkDesc(32'h6000_0000 + a * 32'h10_0000, lens[a], 0);
          descMem[801] = mkDesc(32'h7000_0000 + b * 32'h10_0000, lens[b], 1);
          for (int k = 0; k < 11; k++) begin
            refModel(MEMBASE + 800 * 8, budgets[k]);
            launch(0, MEMBASE + 800 * 8, budgets[k]);
            if (expEnd) finishWalk("R4", "sweep table end");
            else if (budgets[k] == 0) finishWalk("R5", "sweep zero budget");
            else finishWalk("R3", "sweep split R5");
          end
        end
    end

    summary();
  end

endmodule